// File: doc/BRIEF.md
# Two-Output Routed Interrupt Controller

This block merges up to 32 level interrupt sources into two processor request lines, a normal request and a fast request. Each source has an enable bit and a routing bit. An enabled source whose routing bit is 0 drives the normal request. An enabled source whose routing bit is 1 drives the fast request. There is no priority, no vector number and no edge capture. Software finds the pending source by reading the two status words.

Software reaches the block over a simple word-wide register bus. A request is a one-cycle valid strobe with a write flag. Read data and an error flag come back, registered, in the cycle after the request. The enable register has one address that only sets bits and another that only clears bits. Because of this, separate software threads can change different sources without a read-modify-write. The routing register is loaded whole. Four fixed identification words sit at the top of the 4 KiB window.

The source inputs are sampled into a register every cycle. Both request lines are derived from that sampled copy.

Top module: `rsel_intc`

## Requirements
- R1: While reset is asserted, and right after it is released, the enable, routing and sampled-source state are all zero, both request outputs are low, `bus_rdata_o` is 0 and `bus_err_o` is 0.
- R2: `irq_o` is the OR of (sampled & enable & ~route). `fiq_o` is the OR of (sampled & enable & route). The sampled copy takes `src_i` at every clock edge, so a change on `src_i` shows on the outputs after the next edge and not before it.
- R3: A read of offset 0x000 returns sampled & enable & ~route. A read of offset 0x004 returns sampled & enable & route. Read data is valid in the cycle after the request, and `bus_rdata_o` is 0 in every cycle that does not follow a read.
- R4: A read of offset 0x008 returns the sampled source word. A read of 0x00C returns the routing register. A read of 0x010 returns the enable register.
- R5: A write to 0x00C loads the routing register with the write data. A routing bit of 1 sends that source to `fiq_o`, and 0 sends it to `irq_o`.
- R6: A write to 0x010 ORs the write data into the enable register.
- R7: A write to 0x014 clears every enable bit that is 1 in the write data and leaves the others unchanged.
- R8: Reads of 0xFE0, 0xFE4, 0xFE8 and 0xFEC return 0x90, 0x11, 0x04 and 0x00.
- R9: Writes to 0x004, 0x10C and 0x21C change no state and raise no error.
- R10: Only address bits [11:0] are decoded. Higher address bits have no effect.
- R11: A read of any offset other than those in R3, R4 and R8, or a write to any offset other than those in R5, R6, R7 and R9, returns read data 0, changes no state, and sets `bus_err_o` high for exactly the one following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level interrupt sources, 1 = requesting |
| bus_valid_i | input | 1 | Register access strobe, one cycle per access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 32 | Byte address; bits [11:0] decoded |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| bus_err_o | output | 1 | One-cycle flag for an undecoded access |
| irq_o | output | 1 | Normal interrupt request level |
| fiq_o | output | 1 | Fast interrupt request level |

## Verification
The hardest situation to reach from the ports is a source that is enabled and routed to the fast line while a different source drives the normal line at the same time. That state needs a set-enable write, a routing load and a source pattern to all line up. The stimulus builds it in steps: it enables a byte of sources, routes one of them to the fast line, clears that enable, moves the source pattern, and finally enables a high source. Every output is checked after each step. The ignored write offsets are checked only by reading back the enable and routing words afterwards, because those writes have no visible effect at the time.

// File: rtl/rsel_intc.sv
module rsel_intc #(
  parameter int N_SRC = 32,
  parameter int DEC_W = 12,
  parameter logic [7:0] ID0 = 8'h90,
  parameter logic [7:0] ID1 = 8'h11,
  parameter logic [7:0] ID2 = 8'h04,
  parameter logic [7:0] ID3 = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             bus_valid_i,
  input  logic             bus_write_i,
  input  logic [31:0]      bus_addr_i,
  input  logic [N_SRC-1:0] bus_wdata_i,
  output logic [N_SRC-1:0] bus_rdata_o,
  output logic             bus_err_o,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam logic [DEC_W-1:0] OFS_NRM  = DEC_W'(12'h000);
  localparam logic [DEC_W-1:0] OFS_FST  = DEC_W'(12'h004);
  localparam logic [DEC_W-1:0] OFS_RAW  = DEC_W'(12'h008);
  localparam logic [DEC_W-1:0] OFS_RTE  = DEC_W'(12'h00C);
  localparam logic [DEC_W-1:0] OFS_ENS  = DEC_W'(12'h010);
  localparam logic [DEC_W-1:0] OFS_ENC  = DEC_W'(12'h014);
  localparam logic [DEC_W-1:0] OFS_NOP1 = DEC_W'(12'h10C);
  localparam logic [DEC_W-1:0] OFS_NOP2 = DEC_W'(12'h21C);
  localparam logic [DEC_W-1:0] OFS_ID0  = DEC_W'(12'hFE0);
  localparam logic [DEC_W-1:0] OFS_ID1  = DEC_W'(12'hFE4);
  localparam logic [DEC_W-1:0] OFS_ID2  = DEC_W'(12'hFE8);
  localparam logic [DEC_W-1:0] OFS_ID3  = DEC_W'(12'hFEC);

  logic [N_SRC-1:0] smp_q, en_q, rte_q;
  logic [N_SRC-1:0] nrm_st, fst_st, rd_val;
  logic             rd_hit, wr_hit;

  wire [DEC_W-1:0] ofs = bus_addr_i[DEC_W-1:0];
  wire rd = bus_valid_i & ~bus_write_i;
  wire wr = bus_valid_i &  bus_write_i;

  assign nrm_st = smp_q & en_q & ~rte_q;
  assign fst_st = smp_q & en_q &  rte_q;
  assign irq_o  = |nrm_st;
  assign fiq_o  = |fst_st;

  always_comb begin
    rd_hit = 1'b1;
    rd_val = '0;
    case (ofs)
      OFS_NRM: rd_val = nrm_st;
      OFS_FST: rd_val = fst_st;
      OFS_RAW: rd_val = smp_q;
      OFS_RTE: rd_val = rte_q;
      OFS_ENS: rd_val = en_q;
      OFS_ID0: rd_val = N_SRC'(ID0);
      OFS_ID1: rd_val = N_SRC'(ID1);
      OFS_ID2: rd_val = N_SRC'(ID2);
      OFS_ID3: rd_val = N_SRC'(ID3);
      default: rd_hit = 1'b0;
    endcase
  end

  always_comb begin
    case (ofs)
      OFS_FST, OFS_RTE, OFS_ENS, OFS_ENC, OFS_NOP1, OFS_NOP2: wr_hit = 1'b1;
      default: wr_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q       <= '0;
      en_q        <= '0;
      rte_q       <= '0;
      bus_rdata_o <= '0;
      bus_err_o   <= 1'b0;
    end else begin
      smp_q <= src_i;
      if (wr && ofs == OFS_RTE) rte_q <= bus_wdata_i;
      if (wr && ofs == OFS_ENS) en_q  <= en_q | bus_wdata_i;
      if (wr && ofs == OFS_ENC) en_q  <= en_q & ~bus_wdata_i;
      bus_rdata_o <= (rd && rd_hit) ? rd_val : '0;
      bus_err_o   <= (rd && !rd_hit) || (wr && !wr_hit);
    end
  end
endmodule

// File: rtl/rsel_intc_chk.sv
module rsel_intc_chk #(
  parameter int N_SRC = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid_i,
  input logic             bus_write_i,
  input logic [31:0]      bus_addr_i,
  input logic [N_SRC-1:0] bus_wdata_i,
  input logic [N_SRC-1:0] bus_rdata_o,
  input logic             bus_err_o,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [N_SRC-1:0] smp_q,
  input logic [N_SRC-1:0] en_q,
  input logic [N_SRC-1:0] rte_q
);
  wire [11:0] a = bus_addr_i[11:0];
  wire rd = bus_valid_i & ~bus_write_i;
  wire wr = bus_valid_i &  bus_write_i;

  // R2
  quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((smp_q & en_q) == '0) |-> (!irq_o && !fiq_o));
  // R3
  nrm_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd && a == 12'h000) |-> bus_rdata_o == $past(smp_q & en_q & ~rte_q));
  // R4
  raw_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd && a == 12'h008) |-> bus_rdata_o == $past(smp_q));
  // R5
  route_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr && a == 12'h00C) |-> rte_q == $past(bus_wdata_i));
  // R6
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr && a == 12'h010) |-> (en_q & $past(bus_wdata_i)) == $past(bus_wdata_i));
  // R7
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr && a == 12'h014) |-> (en_q & $past(bus_wdata_i)) == '0);
  // R8
  id0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd && a == 12'hFE0) |-> bus_rdata_o == N_SRC'(8'h90));
  // R9
  ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr && (a == 12'h004 || a == 12'h10C || a == 12'h21C)) |->
      (en_q == $past(en_q) && rte_q == $past(rte_q) && !bus_err_o));
  // R11
  err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_o |-> (bus_rdata_o == '0 && $past(bus_valid_i)));
endmodule

bind rsel_intc rsel_intc_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .bus_err_o(bus_err_o), .irq_o(irq_o), .fiq_o(fiq_o),
  .smp_q(smp_q), .en_q(en_q), .rte_q(rte_q)
);

// File: tb/tb_rsel_intc.sv
module tb_rsel_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_valid_i = 1'b0, bus_write_i = 1'b0;
  logic [31:0] bus_addr_i = '0, bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        bus_err_o, irq_o, fiq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rsel_intc dut (.*);

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] src;
    logic [31:0] rdat;
    logic        err;
    logic        irq;
    logic        fiq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 32'h008, 32'h0,        32'hA5A50001, 32'hA5A50001, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b1, 32'h010, 32'hFF,       32'hA5A50001, 32'h0,        1'b0, 1'b1, 1'b0, 4'd6},  // R6
    '{1'b0, 32'h010, 32'h0,        32'hA5A50001, 32'hFF,       1'b0, 1'b1, 1'b0, 4'd4},  // R4
    '{1'b1, 32'h00C, 32'h1,        32'hA5A50001, 32'h0,        1'b0, 1'b0, 1'b1, 4'd5},  // R5
    '{1'b0, 32'h000, 32'h0,        32'hA5A50001, 32'h0,        1'b0, 1'b0, 1'b1, 4'd3},  // R3
    '{1'b0, 32'h004, 32'h0,        32'hA5A50001, 32'h1,        1'b0, 1'b0, 1'b1, 4'd3},  // R3
    '{1'b0, 32'h00C, 32'h0,        32'hA5A50001, 32'h1,        1'b0, 1'b0, 1'b1, 4'd4},  // R4
    '{1'b1, 32'h014, 32'h1,        32'hA5A50001, 32'h0,        1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b0, 32'h000, 32'h0,        32'h00000080, 32'h80,       1'b0, 1'b1, 1'b0, 4'd2},  // R2
    '{1'b1, 32'h004, 32'hFFFFFFFF, 32'h00000080, 32'h0,        1'b0, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b1, 32'h10C, 32'hFFFFFFFF, 32'h00000080, 32'h0,        1'b0, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b1, 32'h21C, 32'hFFFFFFFF, 32'h00000080, 32'h0,        1'b0, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b0, 32'h010, 32'h0,        32'h00000080, 32'hFE,       1'b0, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b0, 32'h00C, 32'h0,        32'h00000080, 32'h1,        1'b0, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b0, 32'hFE0, 32'h0,        32'h00000080, 32'h90,       1'b0, 1'b1, 1'b0, 4'd8},  // R8
    '{1'b0, 32'hFE4, 32'h0,        32'h00000080, 32'h11,       1'b0, 1'b1, 1'b0, 4'd8},  // R8
    '{1'b0, 32'hFE8, 32'h0,        32'h00000080, 32'h04,       1'b0, 1'b1, 1'b0, 4'd8},  // R8
    '{1'b0, 32'hFEC, 32'h0,        32'h00000080, 32'h00,       1'b0, 1'b1, 1'b0, 4'd8},  // R8
    '{1'b0, 32'h12345008, 32'h0,   32'h00000080, 32'h80,       1'b0, 1'b1, 1'b0, 4'd10}, // R10
    '{1'b1, 32'hFFFFF00C, 32'h80,  32'h00000080, 32'h0,        1'b0, 1'b0, 1'b1, 4'd10}, // R10
    '{1'b0, 32'h004, 32'h0,        32'h00000080, 32'h80,       1'b0, 1'b0, 1'b1, 4'd3},  // R3
    '{1'b0, 32'h014, 32'h0,        32'h00000080, 32'h0,        1'b1, 1'b0, 1'b1, 4'd11}, // R11
    '{1'b1, 32'h000, 32'hFF,       32'h00000080, 32'h0,        1'b1, 1'b0, 1'b1, 4'd11}, // R11
    '{1'b0, 32'h10C, 32'h0,        32'h00000080, 32'h0,        1'b1, 1'b0, 1'b1, 4'd11}, // R11
    '{1'b0, 32'hFF0, 32'h0,        32'h00000080, 32'h0,        1'b1, 1'b0, 1'b1, 4'd11}, // R11
    '{1'b1, 32'h010, 32'h100,      32'h00000180, 32'h0,        1'b0, 1'b1, 1'b1, 4'd2},  // R2
    '{1'b0, 32'h000, 32'h0,        32'h00000180, 32'h100,      1'b0, 1'b1, 1'b1, 4'd3},  // R3
    '{1'b0, 32'h004, 32'h0,        32'h00000180, 32'h80,       1'b0, 1'b1, 1'b1, 4'd3}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h, expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] wd);
    @(negedge clk);
    bus_valid_i = 1'b1; bus_write_i = wr; bus_addr_i = addr; bus_wdata_i = wd;
    @(negedge clk);
    bus_valid_i = 1'b0; bus_write_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    src_i = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    // R1 state while held in reset
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 fiq", {31'b0, fiq_o}, 32'h0);
    check("R1 rdata", bus_rdata_o, 32'h0);
    check("R1 err", {31'b0, bus_err_o}, 32'h0);
    src_i = '0;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d v%0d", VEC[i].req, i);
      @(negedge clk);
      src_i = VEC[i].src;
      access(VEC[i].wr, VEC[i].addr, VEC[i].wdata);
      check({tag, " rdata"}, bus_rdata_o, VEC[i].rdat);
      check({tag, " err"}, {31'b0, bus_err_o}, {31'b0, VEC[i].err});
      check({tag, " irq"}, {31'b0, irq_o}, {31'b0, VEC[i].irq});
      check({tag, " fiq"}, {31'b0, fiq_o}, {31'b0, VEC[i].fiq});
    end

    // R11 error lasts one cycle only
    access(1'b0, 32'h018, 32'h0);
    check("R11 err pulse", {31'b0, bus_err_o}, 32'h1);
    @(negedge clk);
    check("R11 err drop", {31'b0, bus_err_o}, 32'h0);
    check("R3 idle rdata", bus_rdata_o, 32'h0);

    // R2 output follows sampled inputs one edge later
    src_i = 32'h0;
    #1;
    check("R2 irq before edge", {31'b0, irq_o}, 32'h1);
    check("R2 fiq before edge", {31'b0, fiq_o}, 32'h1);
    @(negedge clk);
    check("R2 irq after edge", {31'b0, irq_o}, 32'h0);
    check("R2 fiq after edge", {31'b0, fiq_o}, 32'h0);
    src_i = 32'h00000100;
    @(negedge clk);
    check("R2 irq only", {31'b0, irq_o}, 32'h1);
    check("R2 fiq off", {31'b0, fiq_o}, 32'h0);

    // R1 reset clears enable, routing and samples
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    src_i = 32'h0;
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b0, 32'h010, 32'h0);
    check("R1 enable", bus_rdata_o, 32'h0);
    access(1'b0, 32'h00C, 32'h0);
    check("R1 route", bus_rdata_o, 32'h0);
    access(1'b0, 32'h008, 32'h0);
    check("R1 sampled", bus_rdata_o, 32'h0);

    finish_run();
  end
endmodule